// File: doc/BRIEF.md
# Pixel Input Capture with Edge and Pixel-Rate Select

This block sits between an external parallel video source and the downstream line encoders. It samples a 24-bit pixel bus, a second 24-bit pixel bus, a data-enable flag, horizontal and vertical sync, and three general control lines. All of these are sampled on one edge of the source clock. A strap picks which edge does the sampling. A second strap picks whether each source clock carries one pixel or a pair of pixels.

The block always emits one pixel per output clock. In pair mode the output clock runs at twice the source rate, and the pair is sent as two consecutive beats, first pixel first. In single mode the output clock runs at the source rate. An upstream PLL supplies the output clock, frequency-locked to the source clock with their rising edges aligned. An active-low power-down input clears all captured state and holds every output at zero.

The output is a stream with a valid flag and no ready. Video cannot be stalled, so there is no back-pressure. The consumer must accept every cycle in which valid is high.

Top module: `pix_capture`

## Requirements
- R1: With `edge_sel` high, all pixel, enable, sync and control inputs are taken on the rising edge of `idck`.
- R2: With `edge_sel` low, all of those inputs are taken on the falling edge of `idck`.
- R3: With `pair_sel` low, each captured word gives exactly one beat with `pix_valid` high and `pix_data` equal to the `even_pix` value. The beat is visible from the first `oclk` rising edge strictly after the capturing `idck` edge.
- R4: With `pair_sel` high, each captured word gives two beats on consecutive `oclk` cycles. The first beat carries `even_pix` and starts at the same point as in R3. The second beat carries `odd_pix`.
- R5: `de_out`, `hsync_out`, `vsync_out` and `ctl_out` equal the values captured with the word, on every beat that word produces, including both beats of a pair.
- R6: With `pair_sel` low, `odd_pix` has no effect on any output.
- R7: While `pd_n` is low, every output is zero and `pix_valid` is low, and words presented meanwhile produce no beats. After `pd_n` rises, no beat appears until a new word is captured.
- R8: `edge_sel` and `pair_sel` are taken only while `rst_n` or `pd_n` is low. Changes while both are high have no effect.
- R9: In any `oclk` cycle with no beat, `pix_valid` is low and all data, enable, sync and control outputs are zero.
- R10: While `rst_n` is low, `pix_valid` is low and every output is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| oclk | input | 1 | Output pixel clock: 2x `idck` in pair mode, 1x in single mode, rising edges aligned |
| rst_n | input | 1 | Asynchronous active-low reset |
| pd_n | input | 1 | Active-low power-down; clears state and idles outputs |
| edge_sel | input | 1 | Capture edge strap: 1 rising, 0 falling |
| pair_sel | input | 1 | Pixel rate strap: 1 two pixels per `idck`, 0 one pixel |
| idck | input | 1 | Source data clock |
| even_pix | input | 24 | First (or only) pixel of the word |
| odd_pix | input | 24 | Second pixel of the word in pair mode |
| de_in | input | 1 | Active video flag |
| hsync_in | input | 1 | Horizontal sync |
| vsync_in | input | 1 | Vertical sync |
| ctl_in | input | 3 | General control lines |
| pix_valid | output | 1 | Beat present this cycle |
| pix_data | output | 24 | Pixel of the current beat |
| de_out | output | 1 | Active video flag aligned to the beat |
| hsync_out | output | 1 | Horizontal sync aligned to the beat |
| vsync_out | output | 1 | Vertical sync aligned to the beat |
| ctl_out | output | 3 | Control lines aligned to the beat |

## Verification
All four combinations of capture edge and pixel rate are run. Random words are used, with the first word of each burst set to an all-ones even pixel against a fixed odd pattern, so that a swapped or dropped pixel of a pair shows up. Each beat is checked for the exact sampling instant, which tells rising-edge capture apart from falling-edge capture. Random odd data is driven in single mode to expose any leak from the unused bus. The straps are flipped after power-up release to show they are ignored. Words are driven during power-down and followed by a quiet release to show that no stale beat escapes. Bursts separated by gaps in the source clock test the idle-zero rule.

// File: rtl/pxc_pkg.sv
package pxc_pkg;
  localparam int unsigned CTL_W = 3;

  typedef struct packed {
    logic             de;
    logic             hsync;
    logic             vsync;
    logic [CTL_W-1:0] ctl;
  } vtim_t;

  localparam int unsigned VTIM_W = $bits(vtim_t);
endpackage

// File: rtl/pxc_edge_latch.sv
module pxc_edge_latch
  import pxc_pkg::*;
#(
  parameter int unsigned PIX_W = 24,
  parameter bit          RISE  = 1'b1
) (
  input  logic             clk,
  input  logic             hold_n,
  input  logic             en,
  input  logic [PIX_W-1:0] even_i,
  input  logic [PIX_W-1:0] odd_i,
  input  vtim_t            tim_i,
  output logic [PIX_W-1:0] even_q,
  output logic [PIX_W-1:0] odd_q,
  output vtim_t            tim_q,
  output logic             tog_q
);

  if (RISE) begin : g_rise
    always_ff @(posedge clk or negedge hold_n) begin
      if (!hold_n) begin
        even_q <= '0;
        odd_q  <= '0;
        tim_q  <= '0;
        tog_q  <= 1'b0;
      end else if (en) begin
        even_q <= even_i;
        odd_q  <= odd_i;
        tim_q  <= tim_i;
        tog_q  <= ~tog_q;
      end
    end
  end else begin : g_fall
    always_ff @(negedge clk or negedge hold_n) begin
      if (!hold_n) begin
        even_q <= '0;
        odd_q  <= '0;
        tim_q  <= '0;
        tog_q  <= 1'b0;
      end else if (en) begin
        even_q <= even_i;
        odd_q  <= odd_i;
        tim_q  <= tim_i;
        tog_q  <= ~tog_q;
      end
    end
  end

  // The latch on the unselected edge must never move (R1, R2).
  logic act_clk;
  assign act_clk = RISE ? clk : ~clk;

  p_unsel_edge_quiet_r2: assert property (@(posedge act_clk) disable iff (!hold_n)
    !en |=> ($stable(tog_q) && $stable(even_q)));

endmodule

// File: rtl/pxc_capture.sv
module pxc_capture
  import pxc_pkg::*;
#(
  parameter int unsigned PIX_W = 24
) (
  input  logic             clk,
  input  logic             hold_n,
  input  logic             rise_mode,
  input  logic             pair_mode,
  input  logic [PIX_W-1:0] even_i,
  input  logic [PIX_W-1:0] odd_i,
  input  vtim_t            tim_i,
  output logic [PIX_W-1:0] even_o,
  output logic [PIX_W-1:0] odd_o,
  output vtim_t            tim_o,
  output logic             tog_o
);

  localparam int unsigned N_EDGE = 2;

  logic [PIX_W-1:0] even_v [N_EDGE];
  logic [PIX_W-1:0] odd_v  [N_EDGE];
  vtim_t            tim_v  [N_EDGE];
  logic [N_EDGE-1:0] tog_v;
  logic [PIX_W-1:0] odd_m;

  // Second bus is treated as tied low in single-pixel mode (R6).
  assign odd_m = pair_mode ? odd_i : '0;

  for (genvar e = 0; e < N_EDGE; e++) begin : g_edge
    pxc_edge_latch #(
      .PIX_W (PIX_W),
      .RISE  (e == 1)
    ) u_latch (
      .clk    (clk),
      .hold_n (hold_n),
      .en     (rise_mode == (e == 1)),
      .even_i (even_i),
      .odd_i  (odd_m),
      .tim_i  (tim_i),
      .even_q (even_v[e]),
      .odd_q  (odd_v[e]),
      .tim_q  (tim_v[e]),
      .tog_q  (tog_v[e])
    );
  end

  always_comb begin
    even_o = even_v[rise_mode];
    odd_o  = odd_v[rise_mode];
    tim_o  = tim_v[rise_mode];
    tog_o  = tog_v[rise_mode];
  end

endmodule

// File: rtl/pxc_serializer.sv
module pxc_serializer
  import pxc_pkg::*;
#(
  parameter int unsigned PIX_W = 24
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             pd_n,
  input  logic             hold_n,
  input  logic             pair_mode,
  input  logic             tog_i,
  input  logic [PIX_W-1:0] even_i,
  input  logic [PIX_W-1:0] odd_i,
  input  vtim_t            tim_i,
  output logic             o_valid,
  output logic [PIX_W-1:0] o_pix,
  output vtim_t            o_tim
);

  logic             seen_q;
  logic             second_q;
  logic [PIX_W-1:0] odd_hold_q;
  logic             new_word;

  assign new_word = tog_i ^ seen_q;

  always_ff @(posedge clk or negedge hold_n) begin
    if (!hold_n) begin
      seen_q     <= 1'b0;
      second_q   <= 1'b0;
      odd_hold_q <= '0;
      o_valid    <= 1'b0;
      o_pix      <= '0;
      o_tim      <= '0;
    end else begin
      seen_q <= tog_i;
      if (new_word) begin
        o_valid    <= 1'b1;
        o_pix      <= even_i;
        o_tim      <= tim_i;
        odd_hold_q <= odd_i;
        second_q   <= pair_mode;
      end else if (second_q) begin
        o_valid  <= 1'b1;
        o_pix    <= odd_hold_q;
        second_q <= 1'b0;
      end else begin
        o_valid <= 1'b0;
        o_pix   <= '0;
        o_tim   <= '0;
      end
    end
  end

  p_pd_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !pd_n |-> (!o_valid && o_pix == '0 && o_tim == '0));

  p_one_beat_r3: assert property (@(posedge clk) disable iff (!hold_n)
    (!pair_mode && !new_word) |=> !o_valid);

  p_pair_second_r4: assert property (@(posedge clk) disable iff (!hold_n)
    (pair_mode && new_word) |-> ##2 o_valid);

  p_tim_repeat_r5: assert property (@(posedge clk) disable iff (!hold_n)
    (pair_mode && new_word) |-> ##2 $stable(o_tim));

endmodule

// File: rtl/pix_capture.sv
module pix_capture
  import pxc_pkg::*;
#(
  parameter int unsigned PIX_W = 24
) (
  input  logic             oclk,
  input  logic             rst_n,
  input  logic             pd_n,
  input  logic             edge_sel,
  input  logic             pair_sel,
  input  logic             idck,
  input  logic [PIX_W-1:0] even_pix,
  input  logic [PIX_W-1:0] odd_pix,
  input  logic             de_in,
  input  logic             hsync_in,
  input  logic             vsync_in,
  input  logic [CTL_W-1:0] ctl_in,
  output logic             pix_valid,
  output logic [PIX_W-1:0] pix_data,
  output logic             de_out,
  output logic             hsync_out,
  output logic             vsync_out,
  output logic [CTL_W-1:0] ctl_out
);

  logic             hold_n;
  logic             rise_q;
  logic             pair_q;
  vtim_t            tim_in;
  vtim_t            cap_tim;
  vtim_t            out_tim;
  logic [PIX_W-1:0] cap_even;
  logic [PIX_W-1:0] cap_odd;
  logic             cap_tog;

  assign hold_n = rst_n & pd_n;
  assign tim_in = '{de: de_in, hsync: hsync_in, vsync: vsync_in, ctl: ctl_in};

  // Straps are taken only while held in reset or power-down (R8).
  always_ff @(posedge oclk) begin
    if (!hold_n) begin
      rise_q <= edge_sel;
      pair_q <= pair_sel;
    end
  end

  pxc_capture #(.PIX_W(PIX_W)) u_capture (
    .clk       (idck),
    .hold_n    (hold_n),
    .rise_mode (rise_q),
    .pair_mode (pair_q),
    .even_i    (even_pix),
    .odd_i     (odd_pix),
    .tim_i     (tim_in),
    .even_o    (cap_even),
    .odd_o     (cap_odd),
    .tim_o     (cap_tim),
    .tog_o     (cap_tog)
  );

  pxc_serializer #(.PIX_W(PIX_W)) u_serializer (
    .clk       (oclk),
    .rst_n     (rst_n),
    .pd_n      (pd_n),
    .hold_n    (hold_n),
    .pair_mode (pair_q),
    .tog_i     (cap_tog),
    .even_i    (cap_even),
    .odd_i     (cap_odd),
    .tim_i     (cap_tim),
    .o_valid   (pix_valid),
    .o_pix     (pix_data),
    .o_tim     (out_tim)
  );

  assign de_out    = out_tim.de;
  assign hsync_out = out_tim.hsync;
  assign vsync_out = out_tim.vsync;
  assign ctl_out   = out_tim.ctl;

  p_strap_hold_r8: assert property (@(posedge oclk) disable iff (!hold_n)
    $past(hold_n) |-> ($stable(rise_q) && $stable(pair_q)));

endmodule

// File: tb/test_pix_capture.sv
module test_pix_capture;
  localparam int PW = 24;

  logic oclk = 1'b0, idck_free = 1'b0, run = 1'b0, fast = 1'b1;
  wire  idck = idck_free & run;
  logic rst_n = 1'b0, pd_n = 1'b0, edge_sel = 1'b1, pair_sel = 1'b0;
  logic [PW-1:0] even_pix = '0, odd_pix = '0;
  logic de_in = 1'b0, hsync_in = 1'b0, vsync_in = 1'b0;
  logic [2:0] ctl_in = '0;
  logic pix_valid, de_out, hsync_out, vsync_out;
  logic [PW-1:0] pix_data;
  logic [2:0] ctl_out;

  int n_chk = 0, n_fail = 0, k = 0;
  bit mon_on = 1'b0, push_en = 1'b1, done = 1'b0;
  string idle_tag = "R9";

  typedef struct {
    logic [PW-1:0] pix;
    logic [5:0]    tim;
    longint        due;
    bit            rise;
    bit            pair;
    bit            second;
  } beat_t;
  beat_t exp_q[$];
  beat_t cur;

  pix_capture #(.PIX_W(PW)) i_pix_capture (
    .oclk(oclk), .rst_n(rst_n), .pd_n(pd_n), .edge_sel(edge_sel), .pair_sel(pair_sel),
    .idck(idck), .even_pix(even_pix), .odd_pix(odd_pix), .de_in(de_in),
    .hsync_in(hsync_in), .vsync_in(vsync_in), .ctl_in(ctl_in),
    .pix_valid(pix_valid), .pix_data(pix_data), .de_out(de_out),
    .hsync_out(hsync_out), .vsync_out(vsync_out), .ctl_out(ctl_out)
  );

  // 50 MHz output clock; source clock rises together with it.
  initial begin
    forever begin
      #10;
      k = k + 1;
      oclk = k[0];
      idck_free = fast ? k[0] : (((k + 1) % 4) >= 2);
    end
  end

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [63:0] out_word();
    return {pix_valid, pix_data, de_out, hsync_out, vsync_out, ctl_out};
  endfunction

  task automatic set_word(input int i);
    if (i == 0) begin
      even_pix = '1;
      odd_pix  = 24'h0F0F0F;
      {de_in, hsync_in, vsync_in, ctl_in} = 6'b101101;
    end else begin
      even_pix = PW'($urandom);
      odd_pix  = PW'($urandom) | 24'h1;
      {de_in, hsync_in, vsync_in, ctl_in} = 6'($urandom);
    end
  endtask

  task automatic push(input bit rise, input bit pair);
    longint tc, tr;
    logic [5:0] t;
    tc = longint'($time);
    tr = 10 + 20 * ((tc - 10) / 20 + 1);
    t = {de_in, hsync_in, vsync_in, ctl_in};
    exp_q.push_back('{even_pix, t, tr + 10, rise, pair, 1'b0});
    if (pair) exp_q.push_back('{odd_pix, t, tr + 30, rise, pair, 1'b1});
  endtask

  task automatic run_words(input int n, input bit rise, input bit pair);
    set_word(0);
    @(negedge idck_free);
    #1 run = 1'b1;
    for (int i = 0; i < n; i++) begin
      if (rise) @(posedge idck); else @(negedge idck);
      if (push_en) push(rise, pair);
      if (i < n - 1) begin
        if (rise) @(negedge idck); else @(posedge idck);
        #1 set_word(i + 1);
      end
    end
    if (idck_free) @(negedge idck_free);
    #1 run = 1'b0;
  endtask

  // Monitor samples away from the active oclk edge.
  always @(negedge oclk) begin
    if (mon_on && !done) begin
      if (pix_valid) begin
        if (exp_q.size() == 0) begin
          chk(1'b0, {idle_tag, " unexpected beat"}, out_word(), 64'h0);
        end else begin
          cur = exp_q.pop_front();
          chk(pix_data == cur.pix,
              cur.pair ? (cur.second ? "R4 R8 second pixel (odd bus)" : "R4 R8 first pixel (even bus)")
                       : "R3 R6 R8 single pixel",
              pix_data, cur.pix);
          chk({de_out, hsync_out, vsync_out, ctl_out} == cur.tim, "R5 enable/sync/control on beat",
              {de_out, hsync_out, vsync_out, ctl_out}, cur.tim);
          chk(longint'($time) == cur.due, cur.rise ? "R1 rising-edge beat time" : "R2 falling-edge beat time",
              $time, cur.due);
        end
      end else begin
        chk(out_word() == 64'h0, {idle_tag, " idle outputs zero"}, out_word(), 64'h0);
      end
    end
  end

  task automatic do_pass(input bit rise, input bit pair);
    @(negedge oclk);
    #1 pd_n = 1'b0;
    idle_tag = "R7";
    edge_sel = rise;
    pair_sel = pair;
    fast = !pair;
    repeat (3) @(negedge oclk);
    #1 pd_n = 1'b1;
    repeat (4) @(negedge oclk);
    #1 edge_sel = !rise;
    pair_sel = !pair;
    run_words(14, rise, pair);
    idle_tag = "R9";
    repeat (5) @(negedge oclk);
    run_words(10, rise, pair);
    repeat (8) @(negedge oclk);
  endtask

  initial begin
    void'($urandom(32'h5EED_0042));
    repeat (4) @(negedge oclk);
    chk(out_word() == 64'h0, "R10 outputs in reset", out_word(), 64'h0);
    #1 rst_n = 1'b1;
    mon_on = 1'b1;
    idle_tag = "R7";
    push_en = 1'b0;
    run_words(8, 1'b1, 1'b0);
    repeat (3) @(negedge oclk);
    push_en = 1'b1;
    do_pass(1'b1, 1'b0);
    do_pass(1'b0, 1'b0);
    do_pass(1'b1, 1'b1);
    do_pass(1'b0, 1'b1);
    do_pass(1'b1, 1'b0);
    chk(exp_q.size() == 0, "R3 R4 every expected beat delivered", exp_q.size(), 0);
    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    #2000000;
    if (!done) begin
      done = 1'b1;
      chk(1'b0, "watchdog expired", 0, 1);
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

endmodule